// File: doc/BRIEF.md
# Trace Bank Multiplexer with Time-Division Output

This block is the last stage before a set of debug pins that an external measuring instrument watches. Several internal signal banks, each twice as wide as the pin set, are offered to it. One bank at a time is routed to the pins, and the bank is picked while the chip runs. A slow serial control port selects it, in the way a test-access port would. The same control word turns on time-division output, which sends two bank bits per pin in every sample period. It also chooses between two capture modes. In free-running timing mode the instrument samples on its own clock. In state mode the block sends out a sample clock together with the data.

A sample period lasts two cycles of `clk`. The bank is captured once, at the start of each period. With time-division output on, pin i carries bank bit i in the first half of the period and bank bit i+PIN_COUNT in the second half. In state mode, the level of the forwarded clock tells which half is on the pins. A new control word is passed into the `clk` domain with a toggle handshake. It is applied only at a period boundary, so one period never mixes two banks or two settings. The number of observable probe points is NUM_BANKS × PIN_COUNT × 2.

Top module: `trace_bank_mux`

## Requirements
- R1: While `rst_n` is low, `probe_data` and `probe_clk` are 0. After reset, bank 0 is selected, time-division output equals TDM_DEFAULT (1 by default), and timing mode is active.
- R2: In timing mode with time-division output off, `probe_data` is updated at every `clk` edge. It takes bits [PIN_COUNT-1:0] of the selected bank as sampled at that edge.
- R3: The phase toggles at every `clk` edge, and a period starts at the edge where the phase is 0. With time-division output on, that edge captures the full selected bank and puts its low half on the pins. The next edge puts the high half of the same capture on the pins.
- R4: In state mode, `probe_clk` is 0 during the first half of each period and 1 during the second half. With time-division output off, `probe_data` changes only where `probe_clk` falls, so it is stable at its rising edge.
- R5: In timing mode, `probe_clk` stays 0. Time-division output still alternates the low and high halves.
- R6: The control word is shifted in LSB first. Each rising `ctl_clk` edge with `ctl_shift` high shifts in one bit from `ctl_din`, and only the last SEL_W+2 bits are kept. The field layout is: bits [SEL_W-1:0] are the bank index, bit SEL_W is the time-division enable, and bit SEL_W+1 is state mode (1) or timing mode (0).
- R7: Shifting alone changes nothing. A word takes effect only after a rising `ctl_clk` edge with `ctl_update` high and `ctl_shift` low.
- R8: An updated word is carried into the `clk` domain and applied only at the end of a sample period. The bank index and both mode bits therefore change only after a second-half cycle.
- R9: A bank index of NUM_BANKS or more is ignored, and the previous bank stays selected. The two mode bits of that same word are still applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-side clock, two cycles per sample period |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| bank_bus | input | NUM_BANKS*2*PIN_COUNT | All banks side by side, bank k at bits [k*2*PIN_COUNT +: 2*PIN_COUNT] |
| ctl_clk | input | 1 | Serial control clock |
| ctl_shift | input | 1 | Shift enable for the control word |
| ctl_din | input | 1 | Serial control data, LSB first |
| ctl_update | input | 1 | Applies the shifted word |
| probe_data | output | PIN_COUNT | Data driven to the debug pins |
| probe_clk | output | 1 | Forwarded sample clock in state mode, 0 in timing mode |

## Verification
Two things can happen in the same `clk` cycle. One is a new control word being applied at the end of a period. The other is the bank capture, or the half switch, of a time-division output pair. The bench provokes this by shifting in a new bank index while in state mode with time-division output on. The serial clock runs unrelated to `clk`, so the update lands at an arbitrary phase. Every observed pair of halves must then match the low and high half of one bank, either the old one or the new one, never a mix. Random stimulus also changes the bank data in every cycle. A half pair is therefore judged against the value captured at the period start, not against the live input.

// File: rtl/tbm_pkg.sv
package tbm_pkg;

    // widest bank index the block can carry (64 banks)
    localparam int SEL_MAX_W = 6;

    typedef struct packed {
        logic                 state_mode;
        logic                 tdm_en;
        logic [SEL_MAX_W-1:0] bank;
    } tbm_cfg_t;

endpackage

// File: rtl/tbm_ctl_port.sv
module tbm_ctl_port #(
    parameter int WORD_W = 5
) (
    input  logic              ctl_clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              din,
    input  logic              update,
    output logic [WORD_W-1:0] word_q,
    output logic              toggle_q
);

    typedef struct packed {
        logic [WORD_W-1:0] sr;
        logic [WORD_W-1:0] hold;
        logic              tog;
    } ctl_st_t;

    ctl_st_t ctl_q, ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        if (shift_en) begin
            if (WORD_W > 1)
                ctl_d.sr = {din, ctl_q.sr[WORD_W-1:1]};
            else
                ctl_d.sr = din;
        end else if (update) begin
            ctl_d.hold = ctl_q.sr;
            ctl_d.tog  = ~ctl_q.tog;
        end
    end

    always_ff @(posedge ctl_clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign word_q   = ctl_q.hold;
    assign toggle_q = ctl_q.tog;

endmodule

// File: rtl/tbm_sync.sv
module tbm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_in,
    output logic pulse_o
);

    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q, chain_d;

    always_comb begin
        chain_d = {chain_q[CHAIN-2:0], tog_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign pulse_o = chain_q[CHAIN-1] ^ chain_q[CHAIN-2];

endmodule

// File: rtl/tbm_out_stage.sv
module tbm_out_stage #(
    parameter int   NUM_BANKS   = 5,
    parameter int   PIN_COUNT   = 8,
    parameter int   SEL_W       = 3,
    parameter logic TDM_DEFAULT = 1'b1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_BANKS*2*PIN_COUNT-1:0] bank_bus,
    input  logic                             word_pulse,
    input  logic [SEL_W+1:0]                 word,
    output logic [PIN_COUNT-1:0]             probe_data,
    output logic                             probe_clk,
    output logic [SEL_W-1:0]                 cur_sel,
    output logic                             cur_tdm,
    output logic                             cur_state,
    output logic                             cur_phase
);

    localparam int              BANK_W = 2 * PIN_COUNT;
    localparam int              SLOTS  = 1 << SEL_W;
    localparam logic [SEL_W:0]  NB_LIM = NUM_BANKS[SEL_W:0];

    typedef struct packed {
        logic                 phase;
        logic                 pend;
        logic [SEL_W-1:0]     sel;
        logic                 tdm;
        logic                 st;
        logic [BANK_W-1:0]    snap;
        logic [PIN_COUNT-1:0] pins;
        logic                 oclk;
    } out_st_t;

    localparam out_st_t RESET_ST = '{
        phase: 1'b0, pend: 1'b0, sel: '0, tdm: TDM_DEFAULT, st: 1'b0,
        snap: '0, pins: '0, oclk: 1'b0};

    logic [BANK_W-1:0] slot [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g < NUM_BANKS) begin : g_used
            assign slot[g] = bank_bus[g*BANK_W +: BANK_W];
        end else begin : g_pad
            assign slot[g] = '0;
        end
    end

    out_st_t           cr_q, cr_d;
    logic              commit;
    logic [SEL_W-1:0]  word_sel;
    logic [BANK_W-1:0] cur_bank;

    assign word_sel = word[SEL_W-1:0];
    assign cur_bank = slot[cr_q.sel];

    always_comb begin
        cr_d       = cr_q;
        cr_d.phase = ~cr_q.phase;
        commit     = cr_q.phase & cr_q.pend;
        cr_d.pend  = (cr_q.pend & ~commit) | word_pulse;

        if (commit) begin
            if ({1'b0, word_sel} < NB_LIM) cr_d.sel = word_sel;
            cr_d.tdm = word[SEL_W];
            cr_d.st  = word[SEL_W+1];
        end

        if (!cr_q.tdm && !cr_q.st) begin
            cr_d.pins = cur_bank[PIN_COUNT-1:0];
        end else if (!cr_q.phase) begin
            cr_d.snap = cur_bank;
            cr_d.pins = cur_bank[PIN_COUNT-1:0];
        end else if (cr_q.tdm) begin
            cr_d.pins = cr_q.snap[BANK_W-1:PIN_COUNT];
        end

        cr_d.oclk = cr_q.st & cr_q.phase;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cr_q <= RESET_ST;
        else        cr_q <= cr_d;
    end

    assign probe_data = cr_q.pins;
    assign probe_clk  = cr_q.oclk;
    assign cur_sel    = cr_q.sel;
    assign cur_tdm    = cr_q.tdm;
    assign cur_state  = cr_q.st;
    assign cur_phase  = cr_q.phase;

endmodule

// File: rtl/trace_bank_mux.sv
module trace_bank_mux #(
    parameter int   NUM_BANKS   = 5,
    parameter int   PIN_COUNT   = 8,
    parameter logic TDM_DEFAULT = 1'b1,
    parameter int   SYNC_STAGES = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_BANKS*2*PIN_COUNT-1:0] bank_bus,
    input  logic                             ctl_clk,
    input  logic                             ctl_shift,
    input  logic                             ctl_din,
    input  logic                             ctl_update,
    output logic [PIN_COUNT-1:0]             probe_data,
    output logic                             probe_clk
);

    localparam int SEL_W  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int WORD_W = SEL_W + 2;

    logic [WORD_W-1:0] ctl_word;
    logic              ctl_tog;
    logic              word_pulse;
    logic [SEL_W-1:0]  cur_sel;
    logic              cur_tdm;
    logic              cur_state;
    logic              cur_phase;

    tbm_ctl_port #(.WORD_W(WORD_W)) u_ctl (
        .ctl_clk  (ctl_clk),
        .rst_n    (rst_n),
        .shift_en (ctl_shift),
        .din      (ctl_din),
        .update   (ctl_update),
        .word_q   (ctl_word),
        .toggle_q (ctl_tog)
    );

    tbm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .tog_in  (ctl_tog),
        .pulse_o (word_pulse)
    );

    tbm_out_stage #(
        .NUM_BANKS  (NUM_BANKS),
        .PIN_COUNT  (PIN_COUNT),
        .SEL_W      (SEL_W),
        .TDM_DEFAULT(TDM_DEFAULT)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .bank_bus  (bank_bus),
        .word_pulse(word_pulse),
        .word      (ctl_word),
        .probe_data(probe_data),
        .probe_clk (probe_clk),
        .cur_sel   (cur_sel),
        .cur_tdm   (cur_tdm),
        .cur_state (cur_state),
        .cur_phase (cur_phase)
    );

endmodule

// File: rtl/tbm_chk.sv
module tbm_chk #(
    parameter int NUM_BANKS = 5,
    parameter int PIN_COUNT = 8,
    parameter int SEL_W     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [PIN_COUNT-1:0] probe_data,
    input logic                 probe_clk,
    input logic [SEL_W-1:0]     cur_sel,
    input logic                 cur_tdm,
    input logic                 cur_state,
    input logic                 cur_phase
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (probe_data == '0 && !probe_clk));

    // R5
    timing_no_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_state |=> !probe_clk);

    // R4
    state_clk_toggles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state && $past(cur_state)) |=> (probe_clk != $past(probe_clk)));

    // R4
    stable_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(probe_clk) && $past(!cur_tdm)) |-> $stable(probe_data));

    // R8
    commit_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_sel != $past(cur_sel) || cur_tdm != $past(cur_tdm) ||
         cur_state != $past(cur_state)) |-> $past(cur_phase));

    // R9
    sel_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cur_sel) < NUM_BANKS);

endmodule

bind trace_bank_mux tbm_chk #(
    .NUM_BANKS(NUM_BANKS),
    .PIN_COUNT(PIN_COUNT),
    .SEL_W    (SEL_W)
) u_tbm_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .probe_data(probe_data),
    .probe_clk (probe_clk),
    .cur_sel   (cur_sel),
    .cur_tdm   (cur_tdm),
    .cur_state (cur_state),
    .cur_phase (cur_phase)
);

// File: tb/tb_trace_bank_mux.sv
module tb_trace_bank_mux;

    localparam int NB = 5;
    localparam int P  = 8;
    localparam int SW = 3;
    localparam int WW = SW + 2;
    localparam int BW = NB * 2 * P;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_clk = 1'b0;
    logic          ctl_shift = 1'b0;
    logic          ctl_din = 1'b0;
    logic          ctl_update = 1'b0;
    logic [BW-1:0] bank_bus = '0;
    logic [P-1:0]  probe_data;
    logic          probe_clk;

    always #10 clk = ~clk;

    trace_bank_mux #(.NUM_BANKS(NB), .PIN_COUNT(P), .TDM_DEFAULT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .bank_bus(bank_bus),
        .ctl_clk(ctl_clk), .ctl_shift(ctl_shift), .ctl_din(ctl_din),
        .ctl_update(ctl_update), .probe_data(probe_data), .probe_clk(probe_clk));

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model of the committed configuration and output
    int             m_sel = 0;
    bit             m_tdm = 1'b1;
    bit             m_st = 1'b0;
    bit             ph = 1'b0;
    logic [2*P-1:0] m_snap = '0;
    logic [P-1:0]   m_out = '0;
    bit             m_oclk = 1'b0;

    function automatic logic [2*P-1:0] bank_of(input logic [BW-1:0] bus, input int k);
        return bus[k*2*P +: 2*P];
    endfunction

    function automatic logic [BW-1:0] rand_bus();
        logic [BW-1:0] v;
        for (int i = 0; i < BW; i += 32) v[i +: 16] = 16'($urandom());
        for (int i = 16; i < BW; i += 32) v[i +: 16] = 16'($urandom());
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [P:0] act, input logic [P:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drives banks at a falling edge, models the next rising edge, samples at the falling edge after it
    task automatic tick(input bit chk, input logic [BW-1:0] nb, input string req);
        logic [2*P-1:0] cur;
        bank_bus = nb;
        @(posedge clk);
        cur = bank_of(nb, m_sel);
        if (!m_tdm && !m_st) m_out = cur[P-1:0];
        else if (!ph) begin
            m_snap = cur;
            m_out  = cur[P-1:0];
        end else if (m_tdm) m_out = m_snap[2*P-1:P];
        m_oclk = m_st & ph;
        ph = ~ph;
        @(negedge clk);
        if (chk)
            check({probe_clk, probe_data} === {m_oclk, m_out}, req,
                  {probe_clk, probe_data}, {m_oclk, m_out});
    endtask

    task automatic ser_send(input logic [WW-1:0] w, input bit upd);
        for (int i = 0; i < WW; i++) begin
            ctl_din = w[i];
            ctl_shift = 1'b1;
            #40 ctl_clk = 1'b1;
            #40 ctl_clk = 1'b0;
        end
        ctl_shift = 1'b0;
        if (upd) begin
            ctl_update = 1'b1;
            #40 ctl_clk = 1'b1;
            #40 ctl_clk = 1'b0;
            ctl_update = 1'b0;
        end
    endtask

    task automatic configure(input int sel, input bit tdm, input bit st, input bit upd,
                             input logic [BW-1:0] nb);
        logic [WW-1:0] w;
        w = {st, tdm, SW'(sel)};
        if (upd) begin
            if (sel < NB) m_sel = sel;
            m_tdm = tdm;
            m_st  = st;
        end
        fork
            ser_send(w, upd);
            repeat (45) tick(1'b0, nb, "");
        join
    endtask

    task automatic run_checked(input int n, input string req);
        for (int i = 0; i < n; i++) tick(1'b1, rand_bus(), req);
    endtask

    initial begin
        logic [BW-1:0] fixed;
        logic [P-1:0]  v0;
        bit            have0;
        bit            ok;
        void'($urandom(32'h5eed_2024));

        #5;
        // R1: quiet outputs during reset
        check(probe_data === '0 && probe_clk === 1'b0, "R1 reset",
              {probe_clk, probe_data}, '0);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 defaults: bank 0, time-division on, timing mode (R3, R5 too)
        run_checked(20, "R1 default config");

        // R2: timing mode, no time-division
        configure(2, 1'b0, 1'b0, 1'b1, rand_bus());
        run_checked(20, "R2 timing direct");

        // R4 and R6: last valid bank 4, state mode, no time-division
        configure(4, 1'b0, 1'b1, 1'b1, rand_bus());
        run_checked(20, "R4 R6 state plain");

        // R3 with R4: time-division in state mode
        configure(3, 1'b1, 1'b1, 1'b1, rand_bus());
        run_checked(20, "R3 R4 state tdm");

        // R5: time-division in timing mode
        configure(1, 1'b1, 1'b0, 1'b1, rand_bus());
        run_checked(20, "R5 timing tdm");

        // R7: shift without update changes nothing
        configure(0, 1'b0, 1'b1, 1'b0, rand_bus());
        run_checked(16, "R7 shift only");

        // R9: bank 6 is out of range, mode bits still applied
        configure(6, 1'b0, 1'b0, 1'b1, rand_bus());
        run_checked(16, "R9 bad index");
        configure(7, 1'b1, 1'b1, 1'b1, rand_bus());
        run_checked(16, "R9 bad index modes");

        // R8: update lands mid-stream in state mode with time-division on
        fixed = rand_bus();
        configure(1, 1'b1, 1'b1, 1'b1, fixed);
        m_sel = 3;
        have0 = 1'b0;
        v0 = '0;
        fork
            ser_send({1'b1, 1'b1, SW'(3)}, 1'b1);
            for (int i = 0; i < 45; i++) begin
                tick(1'b0, fixed, "");
                if (probe_clk && have0) begin
                    ok = (v0 == bank_of(fixed, 1)[P-1:0] && probe_data == bank_of(fixed, 1)[2*P-1:P]) ||
                         (v0 == bank_of(fixed, 3)[P-1:0] && probe_data == bank_of(fixed, 3)[2*P-1:P]);
                    check(ok, "R8 no mixed halves", {1'b1, probe_data}, {1'b1, v0});
                end
                if (!probe_clk) begin
                    v0 = probe_data;
                    have0 = 1'b1;
                end
            end
        join
        run_checked(16, "R8 after switch");

        // random configurations, R6 word layout across all fields
        for (int r = 0; r < 12; r++) begin
            configure(int'($urandom_range(0, 7)), 1'($urandom()), 1'($urandom()), 1'b1, rand_bus());
            run_checked(24, "R6 random word");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule